// File: doc/BRIEF.md
# Paged Program Counter

This block holds the 12-bit instruction address of a small 8-bit controller whose 4096-byte program store is cut into 256-byte pages (the upper hex digit of the address is the page) and into two 2K halves selected by address bit 11. Sequential fetches advance only the low byte, so straight-line code wraps around inside its own page instead of running into the next one.

Leaving a page is only possible through a jump or call, which supplies the low 11 address bits. Bit 11 is then taken from a bank-choice flag that software sets or clears ahead of time. Writing that flag does nothing to the running address. The flag reaches bit 11 only at the next jump or call. A separate restore path loads all 12 bits at once, which is how a return from subroutine puts back an address popped from the stack.

Top module: `paged_pc`

## Requirements
- R1: While `rst_ni` is low and after it rises, `pc_o` is 0x000 and the bank-choice flag is 0, so a jump before any flag write lands in the lower 2K.
- R2: When `step_i` is the only active strobe, bits 7:0 of `pc_o` go up by one on the next clock (0xFF wraps to 0x00), and bits 11:8 stay as they were.
- R3: When `jump_i` is high and `restore_i` is low, the next `pc_o` is {bank-choice flag, `jump_tgt_i[10:0]`}.
- R4: `bank_set_i` sets the bank-choice flag and `bank_clr_i` clears it. If both are high in the same cycle, the clear wins.
- R5: A flag write changes `pc_o` in no way until a jump loads it. Bit 11 of `pc_o` changes only on a jump or a restore.
- R6: A jump in the same cycle as a flag write uses the flag value that was held before that cycle.
- R7: When `restore_i` is high, the next `pc_o` equals `restore_pc_i` in all 12 bits. The bank-choice flag is not changed by a restore.
- R8: Priority among the address strobes is restore, then jump, then step.
- R9: With no address strobe active, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance to the next byte within the page |
| jump_i | input | 1 | Load a jump or call target |
| jump_tgt_i | input | 11 | Target bits 10:0 for a jump or call |
| bank_set_i | input | 1 | Set the bank-choice flag |
| bank_clr_i | input | 1 | Clear the bank-choice flag |
| restore_i | input | 1 | Load a full address from the stack |
| restore_pc_i | input | 12 | Full 12-bit address to restore |
| pc_o | output | 12 | Current program address |

## Verification
The assertions take for granted that every strobe has a known value at each clock edge once reset is released. They do not assume that the strobes exclude each other. Each property is written for the winning source, so overlapping strobes are legal input.

The stimulus holds every strobe low during reset. It then drives any mix of strobes, including all of them at once and set together with clear, so the priority paths and the same-cycle flag case are reached under the same rules that the properties state.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

    localparam int unsigned PC_W_DEF   = 12;
    localparam int unsigned PAGE_W_DEF = 8;

    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_STEP    = 2'd1,
        SRC_JUMP    = 2'd2,
        SRC_RESTORE = 2'd3
    } pc_src_e;

endpackage

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter
    import paged_pc_pkg::*;
(
    input  logic    step_i,
    input  logic    jump_i,
    input  logic    restore_i,
    output pc_src_e src_o
);
    // restore beats jump, jump beats step
    always_comb begin
        if (restore_i)   src_o = SRC_RESTORE;
        else if (jump_i) src_o = SRC_JUMP;
        else if (step_i) src_o = SRC_STEP;
        else             src_o = SRC_HOLD;
    end
endmodule

// File: rtl/pc_page_step.sv
module pc_page_step #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] pc_o
);
    logic [PAGE_W-1:0] low_next;

    assign low_next = pc_i[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign pc_o = low_next[ADDR_W-1:0];
        end else begin : g_paged
            // the page field is carried through untouched
            assign pc_o = {pc_i[ADDR_W-1:PAGE_W], low_next};
        end
    endgenerate
endmodule

// File: rtl/pc_bank_flag.sv
module pc_bank_flag (
    input  logic flag_q_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_d_o
);
    // clear has priority over set
    always_comb begin
        if (clr_i)      flag_d_o = 1'b0;
        else if (set_i) flag_d_o = 1'b1;
        else            flag_d_o = flag_q_i;
    end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import paged_pc_pkg::*;
#(
    parameter int unsigned ADDR_W = PC_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic [ADDR_W-2:0] jump_tgt_i,
    input  logic              bank_set_i,
    input  logic              bank_clr_i,
    input  logic              restore_i,
    input  logic [ADDR_W-1:0] restore_pc_i,
    output logic [ADDR_W-1:0] pc_o
);
    localparam int unsigned TGT_W = ADDR_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              bank_flag;
    } pc_state_t;

    pc_state_t state_d, state_q;

    pc_src_e           src;
    logic [ADDR_W-1:0] pc_stepped;
    logic              flag_next;
    logic              bank_flag_w;

    pc_src_arbiter u_arb (
        .step_i    (step_i),
        .jump_i    (jump_i),
        .restore_i (restore_i),
        .src_o     (src)
    );

    pc_page_step #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_step (
        .pc_i (state_q.pc),
        .pc_o (pc_stepped)
    );

    pc_bank_flag u_flag (
        .flag_q_i (state_q.bank_flag),
        .set_i    (bank_set_i),
        .clr_i    (bank_clr_i),
        .flag_d_o (flag_next)
    );

    always_comb begin
        state_d           = state_q;
        state_d.bank_flag = flag_next;
        unique case (src)
            SRC_RESTORE: state_d.pc = restore_pc_i;
            // a jump takes the flag as held before this cycle
            SRC_JUMP:    state_d.pc = {state_q.bank_flag, jump_tgt_i[TGT_W-1:0]};
            SRC_STEP:    state_d.pc = pc_stepped;
            default:     state_d.pc = state_q.pc;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o        = state_q.pc;
    assign bank_flag_w = state_q.bank_flag;

endmodule

// File: rtl/paged_pc_checker.sv
module paged_pc_checker #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PAGE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              step_i,
    input logic              jump_i,
    input logic [ADDR_W-2:0] jump_tgt_i,
    input logic              bank_set_i,
    input logic              bank_clr_i,
    input logic              restore_i,
    input logic [ADDR_W-1:0] restore_pc_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic              bank_flag
);
    p_step_page_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !jump_i && !restore_i) |=>
        (pc_o[ADDR_W-1:PAGE_W] == $past(pc_o[ADDR_W-1:PAGE_W])) &&
        (pc_o[PAGE_W-1:0] == $past(pc_o[PAGE_W-1:0]) + 1'b1));

    p_jump_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (jump_i && !restore_i) |=>
        (pc_o == {$past(bank_flag), $past(jump_tgt_i)}));

    p_clear_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_clr_i |=> !bank_flag);

    p_set_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bank_set_i && !bank_clr_i) |=> bank_flag);

    p_bank_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!jump_i && !restore_i) |=> (pc_o[ADDR_W-1] == $past(pc_o[ADDR_W-1])));

    p_restore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_i |=> (pc_o == $past(restore_pc_i)));

    p_restore_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restore_i && !bank_set_i && !bank_clr_i) |=> $stable(bank_flag));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !jump_i && !restore_i) |=> $stable(pc_o));

endmodule

bind paged_pc paged_pc_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .jump_tgt_i   (jump_tgt_i),
    .bank_set_i   (bank_set_i),
    .bank_clr_i   (bank_clr_i),
    .restore_i    (restore_i),
    .restore_pc_i (restore_pc_i),
    .pc_o         (pc_o),
    .bank_flag    (bank_flag_w)
);

// File: tb/tb_paged_pc.sv
`timescale 1ns/1ps
module tb_paged_pc;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        step_i = 1'b0, jump_i = 1'b0, restore_i = 1'b0;
    logic        bank_set_i = 1'b0, bank_clr_i = 1'b0;
    logic [10:0] jump_tgt_i = '0;
    logic [11:0] restore_pc_i = '0;
    logic [11:0] pc_o;

    int unsigned n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;
    logic [11:0] m_pc = '0;
    logic        m_flag = 1'b0;

    always #5 clk_i = ~clk_i;

    paged_pc dut (
        .clk_i (clk_i), .rst_ni (rst_ni), .step_i (step_i), .jump_i (jump_i),
        .jump_tgt_i (jump_tgt_i), .bank_set_i (bank_set_i), .bank_clr_i (bank_clr_i),
        .restore_i (restore_i), .restore_pc_i (restore_pc_i), .pc_o (pc_o)
    );

    function automatic logic [11:0] ref_pc(logic [11:0] pc, logic flag, logic st,
                                           logic jp, logic [10:0] tg, logic rs,
                                           logic [11:0] rp);
        if (rs)      return rp;
        else if (jp) return {flag, tg};
        else if (st) return {pc[11:8], pc[7:0] + 8'd1};
        else         return pc;
    endfunction

    function automatic logic ref_flag(logic flag, logic s, logic c);
        return c ? 1'b0 : (s ? 1'b1 : flag);
    endfunction

    function automatic string req_of(logic st, logic jp, logic rs, logic s, logic c);
        if (rs)          return "R7";
        else if (jp)     return (s || c) ? "R6" : "R3";
        else if (s || c) return "R5";
        else if (st)     return "R2";
        else             return "R9";
    endfunction

    task automatic check(string req, logic [11:0] got, logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pc_o=%03h expected=%03h", req, got, exp);
        end
    endtask

    // one clock with given strobes; model and check after the edge
    task automatic cyc(logic st, logic jp, logic [10:0] tg, logic s, logic c,
                       logic rs, logic [11:0] rp, string req);
        @(negedge clk_i);
        step_i = st; jump_i = jp; jump_tgt_i = tg; bank_set_i = s;
        bank_clr_i = c; restore_i = rs; restore_pc_i = rp;
        @(posedge clk_i);
        #1;
        m_pc   = ref_pc(m_pc, m_flag, st, jp, tg, rs, rp);
        m_flag = ref_flag(m_flag, s, c);
        check(req, pc_o, m_pc);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: pc_o=%03h expected=end of run", pc_o);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk_i);
        #1 check("R1", pc_o, 12'h000);
        @(negedge clk_i) rst_ni = 1'b1;
        @(posedge clk_i); #1 check("R1", pc_o, 12'h000);
        // R1: flag cleared -> jump lands low
        cyc(0, 1, 11'h7F0, 0, 0, 0, '0, "R1");
        // R2: wrap inside the page
        cyc(0, 0, '0, 0, 0, 1, 12'h3FE, "R7");
        cyc(1, 0, '0, 0, 0, 0, '0, "R2");
        cyc(1, 0, '0, 0, 0, 0, '0, "R2");
        check("R2", pc_o, 12'h300);
        // R5: set flag, steps keep bit 11 low
        cyc(1, 0, '0, 1, 0, 0, '0, "R5");
        cyc(1, 0, '0, 0, 0, 0, '0, "R5");
        check("R5", pc_o, 12'h302);
        // R3: jump picks up the flag
        cyc(0, 1, 11'h123, 0, 0, 0, '0, "R3");
        check("R3", pc_o, 12'h923);
        // R6: clear with jump uses old flag, next jump sees new
        cyc(0, 1, 11'h045, 0, 1, 0, '0, "R6");
        check("R6", pc_o, 12'h845);
        cyc(0, 1, 11'h045, 0, 0, 0, '0, "R6");
        check("R6", pc_o, 12'h045);
        // R4: set and clear together -> clear
        cyc(0, 0, '0, 1, 1, 0, '0, "R4");
        cyc(0, 1, 11'h600, 0, 0, 0, '0, "R4");
        check("R4", pc_o, 12'h600);
        // R7: restore with upper bank, flag untouched
        cyc(0, 0, '0, 0, 0, 1, 12'hABC, "R7");
        cyc(0, 1, 11'h011, 0, 0, 0, '0, "R7");
        check("R7", pc_o, 12'h011);
        // R8: priority
        cyc(1, 1, 11'h222, 1, 0, 1, 12'hF0F, "R8");
        check("R8", pc_o, 12'hF0F);
        cyc(1, 1, 11'h222, 0, 0, 0, '0, "R8");
        check("R8", pc_o, 12'hA22);
        // R9: hold
        cyc(0, 0, '0, 0, 0, 0, '0, "R9");
        check("R9", pc_o, 12'hA22);
        for (int i = 0; i < 3000; i++) begin
            logic st, jp, s, c, rs;
            logic [10:0] tg;
            logic [11:0] rp;
            st = ($urandom % 4) != 0;
            jp = ($urandom % 6) == 0;
            rs = ($urandom % 12) == 0;
            s  = ($urandom % 8) == 0;
            c  = ($urandom % 8) == 0;
            tg = 11'($urandom);
            rp = 12'($urandom);
            cyc(st, jp, tg, s, c, rs, rp, req_of(st, jp, rs, s, c));
        end
        finish_run();
    end
endmodule